// File: doc/BRIEF.md
# SRAM Window Register Bank

This block is an AXI4-Lite slave that exposes an external synchronous SRAM as a window of 32-bit elements in its address space. It keeps no data of its own. A bus write is turned into one SRAM write cycle, with per-byte write enables. A bus read is turned into an SRAM read, and the bank waits out the SRAM's one-cycle latency before it returns the data on the read channel.

A build-time parameter picks one of three access modes: read-write, write-only or read-only. In write-only mode the SRAM is filled from the bus and read only by neighbouring user logic, so bus reads of the window return zero. In read-only mode the SRAM is filled by user logic and bus writes are dropped. Addresses outside the window still get a response: OKAY, with zero read data, and the SRAM is left alone.

One controller handles one transaction at a time. Its states are IDLE, WACK (write response pending), RADDR (SRAM address on the bus), RLAT (SRAM read latency) and RACK (read response pending). The transitions are:
- IDLE to WACK when a write address and write data are both accepted.
- IDLE to RADDR when an in-window read is accepted and reads are allowed.
- IDLE straight to RACK for a read that is outside the window, or any read in write-only mode.
- RADDR to RLAT, then RLAT to RACK, with no condition.
- WACK to IDLE on BREADY.
- RACK to IDLE on RREADY.

Top module: `sram_window_bank`

## Requirements
- R1: After reset, s_bvalid, s_rvalid and mem_we are all 0.
- R2: A bus byte address A with WIN_BASE <= A < WIN_BASE + 4*DEPTH hits element (A - WIN_BASE) >> 2. Address bits [1:0] do not change which element is selected. With the defaults, the window spans 0x0040 to 0x007F.
- R3: When a write is accepted at a clock edge, the next cycle shows mem_we equal to the accepted s_wstrb, mem_addr equal to the element, mem_wdata equal to s_wdata, and s_bvalid high. In the cycle after that, mem_we is 0 again.
- R4: A write changes only the byte lanes whose strobe bit is 1. Bit b of s_wstrb covers data bits [8b+7:8b].
- R5: An in-window read in read-write mode raises s_rvalid in the third cycle after the handshake edge. The returned data is the SRAM word at that element.
- R6: Between a read handshake and the return of its response, s_arready, s_awready and s_wready stay low, so only one transaction is outstanding.
- R7: In write-only mode (MODE = ACC_WO), an in-window read returns zero data in the cycle after the handshake. In-window writes still drive mem_we.
- R8: In read-only mode (MODE = ACC_RO), mem_we never rises and the SRAM contents are left unchanged by bus writes.
- R9: A write outside the window drives no mem_we. A read outside the window returns zero in the cycle after the handshake.
- R10: If a write (address and data) and a read are both valid in IDLE, the write is accepted first and s_arready stays low in that cycle.
- R11: s_bresp and s_rresp are always OKAY (2'b00) while their valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_awaddr | input | ADDR_W | Write byte address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | DATA_W | Write data |
| s_wstrb | input | DATA_W/8 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read byte address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | DATA_W | Read data |
| s_rresp | output | 2 | Read response |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| mem_addr | output | EL_W | SRAM element address |
| mem_wdata | output | DATA_W | SRAM write data |
| mem_we | output | DATA_W/8 | SRAM byte write enables |
| mem_rdata | input | DATA_W | SRAM read data (one-cycle latency) |

## Verification
The bench builds three copies of the block, one per access mode, each with its own SRAM model, and drives them with the same bus traffic. Random addresses are drawn from a range that straddles both window edges. Random byte offsets and random strobe patterns are added, so the tests tell apart element decode, byte-lane merging, and the three per-mode paths for the same access. Directed cases cover the first and last elements, the addresses just outside the window, and a write and a read arriving together, which shows whether the write is given priority.

// File: rtl/sramwin_pkg.sv
package sramwin_pkg;
    typedef enum logic [1:0] {
        ACC_RW = 2'd0,
        ACC_WO = 2'd1,
        ACC_RO = 2'd2
    } acc_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_WACK  = 3'd1,
        ST_RADDR = 3'd2,
        ST_RLAT  = 3'd3,
        ST_RACK  = 3'd4
    } win_state_e;

    localparam logic [1:0] RESP_OKAY = 2'b00;
endpackage

// File: rtl/sramwin_decode.sv
module sramwin_decode #(
    parameter int                ADDR_W   = 16,
    parameter int                DEPTH    = 16,
    parameter int                EL_W     = 4,
    parameter logic [ADDR_W-1:0] WIN_BASE = 16'h0040
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic              hit_o,
    output logic [EL_W-1:0]   idx_o
);
    localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(4 * DEPTH);

    logic [ADDR_W-1:0] off;
    logic              unused_bits;

    assign off         = addr_i - WIN_BASE;
    assign hit_o       = (addr_i >= WIN_BASE) && (off < SPAN);
    assign idx_o       = off[EL_W+1:2];
    assign unused_bits = ^{off[ADDR_W-1:EL_W+2], off[1:0]};
endmodule

// File: rtl/sram_window_bank.sv
module sram_window_bank
    import sramwin_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter int                DATA_W   = 32,
    parameter int                DEPTH    = 16,
    parameter logic [ADDR_W-1:0] WIN_BASE = 16'h0040,
    parameter acc_mode_e         MODE     = ACC_RW,
    localparam int               STRB_W   = DATA_W / 8,
    localparam int               EL_W     = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] s_awaddr,
    input  logic              s_awvalid,
    output logic              s_awready,
    input  logic [DATA_W-1:0] s_wdata,
    input  logic [STRB_W-1:0] s_wstrb,
    input  logic              s_wvalid,
    output logic              s_wready,
    output logic [1:0]        s_bresp,
    output logic              s_bvalid,
    input  logic              s_bready,
    input  logic [ADDR_W-1:0] s_araddr,
    input  logic              s_arvalid,
    output logic              s_arready,
    output logic [DATA_W-1:0] s_rdata,
    output logic [1:0]        s_rresp,
    output logic              s_rvalid,
    input  logic              s_rready,
    output logic [EL_W-1:0]   mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [STRB_W-1:0] mem_we,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam bit CAN_WRITE = (MODE != ACC_RO);
    localparam bit CAN_READ  = (MODE != ACC_WO);

    win_state_e      st_q, st_d;
    logic            w_hit, r_hit;
    logic [EL_W-1:0] w_idx, r_idx;
    logic            wr_go, rd_go;

    sramwin_decode #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .EL_W(EL_W), .WIN_BASE(WIN_BASE))
        u_wdec (.addr_i(s_awaddr), .hit_o(w_hit), .idx_o(w_idx));

    sramwin_decode #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .EL_W(EL_W), .WIN_BASE(WIN_BASE))
        u_rdec (.addr_i(s_araddr), .hit_o(r_hit), .idx_o(r_idx));

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Next state and handshake outputs
    always_comb begin
        st_d      = st_q;
        s_awready = 1'b0;
        s_wready  = 1'b0;
        s_arready = 1'b0;
        wr_go     = 1'b0;
        rd_go     = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (s_awvalid && s_wvalid) begin
                    s_awready = 1'b1;
                    s_wready  = 1'b1;
                    wr_go     = 1'b1;
                    st_d      = ST_WACK;
                end else begin
                    s_arready = 1'b1;
                    if (s_arvalid) begin
                        rd_go = 1'b1;
                        st_d  = (r_hit && CAN_READ) ? ST_RADDR : ST_RACK;
                    end
                end
            end
            ST_WACK:  if (s_bready) st_d = ST_IDLE;
            ST_RADDR: st_d = ST_RLAT;
            ST_RLAT:  st_d = ST_RACK;
            ST_RACK:  if (s_rready) st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    assign s_bvalid = (st_q == ST_WACK);
    assign s_rvalid = (st_q == ST_RACK);
    assign s_bresp  = RESP_OKAY;
    assign s_rresp  = RESP_OKAY;

    // Registered SRAM-side and read-data outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr  <= '0;
            mem_wdata <= '0;
            mem_we    <= '0;
            s_rdata   <= '0;
        end else begin
            mem_we <= '0;
            if (wr_go && w_hit) begin
                mem_addr  <= w_idx;
                mem_wdata <= s_wdata;
                if (CAN_WRITE) mem_we <= s_wstrb;
            end
            if (rd_go) begin
                s_rdata <= '0;
                if (r_hit && CAN_READ) mem_addr <= r_idx;
            end
            if (st_q == ST_RLAT) s_rdata <= mem_rdata;
        end
    end

    // Assertions
    assert_we_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we != '0) |=> (mem_we == '0));

    assert_we_follows_hs_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_awvalid && s_awready && s_wvalid && s_wready && w_hit && CAN_WRITE)
        |=> (mem_we == $past(s_wstrb) && s_bvalid));

    assert_ro_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!CAN_WRITE) |-> (mem_we == '0));

    assert_miss_nowe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (s_awvalid && s_awready && !w_hit) |=> (mem_we == '0));

    assert_rd_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_arvalid && s_arready && r_hit && CAN_READ)
        |-> ##3 (s_rvalid && s_rdata == $past(mem_rdata)));

    assert_rd_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_arvalid && s_arready && !(r_hit && CAN_READ)) |=> (s_rvalid && s_rdata == '0));

    assert_one_outstanding_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_rvalid || s_bvalid) |-> (!s_arready && !s_awready && !s_wready));

    assert_wr_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (s_awready && s_wready) |-> !s_arready);

    assert_okay_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (s_bvalid || s_rvalid) |-> (s_bresp == 2'b00 && s_rresp == 2'b00));
endmodule

// File: tb/tb_sram_model.sv
module tb_sram_model #(
    parameter int DEPTH = 16,
    parameter int AW    = 4
) (
    input  logic          clk,
    input  logic [AW-1:0] addr,
    input  logic [31:0]   wdata,
    input  logic [3:0]    we,
    output logic [31:0]   rdata
);
    logic [31:0] mem [DEPTH];

    initial begin
        for (int i = 0; i < DEPTH; i++) mem[i] = 32'hA500_0000 + 32'(i) * 32'h0001_0203;
        rdata = '0;
    end

    always @(posedge clk) begin
        for (int b = 0; b < 4; b++)
            if (we[b]) mem[addr][8*b +: 8] <= wdata[8*b +: 8];
        rdata <= mem[addr];
    end
endmodule

// File: tb/tb_sram_window_bank.sv
module tb_sram_window_bank;
    import sramwin_pkg::*;

    localparam int          DEPTH = 16;
    localparam logic [15:0] BASE  = 16'h0040;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [15:0] awaddr = '0, araddr = '0;
    logic        awvalid = 0, wvalid = 0, arvalid = 0;
    logic [31:0] wdata = '0;
    logic [3:0]  wstrb = '0;
    logic        bready = 1'b1, rready = 1'b1;

    logic        awr [3], wrd [3], arr [3], bv [3], rv [3];
    logic [1:0]  br [3], rr [3];
    logic [31:0] rd [3], mwd [3], mrd [3];
    logic [3:0]  ma [3], mwe [3];

    sram_window_bank #(.WIN_BASE(BASE), .DEPTH(DEPTH), .MODE(ACC_RW)) dut (
        .clk, .rst_n, .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awr[0]),
        .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid), .s_wready(wrd[0]),
        .s_bresp(br[0]), .s_bvalid(bv[0]), .s_bready(bready),
        .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arr[0]),
        .s_rdata(rd[0]), .s_rresp(rr[0]), .s_rvalid(rv[0]), .s_rready(rready),
        .mem_addr(ma[0]), .mem_wdata(mwd[0]), .mem_we(mwe[0]), .mem_rdata(mrd[0]));
    sram_window_bank #(.WIN_BASE(BASE), .DEPTH(DEPTH), .MODE(ACC_WO)) dut_wo (
        .clk, .rst_n, .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awr[1]),
        .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid), .s_wready(wrd[1]),
        .s_bresp(br[1]), .s_bvalid(bv[1]), .s_bready(bready),
        .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arr[1]),
        .s_rdata(rd[1]), .s_rresp(rr[1]), .s_rvalid(rv[1]), .s_rready(rready),
        .mem_addr(ma[1]), .mem_wdata(mwd[1]), .mem_we(mwe[1]), .mem_rdata(mrd[1]));
    sram_window_bank #(.WIN_BASE(BASE), .DEPTH(DEPTH), .MODE(ACC_RO)) dut_ro (
        .clk, .rst_n, .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awr[2]),
        .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid), .s_wready(wrd[2]),
        .s_bresp(br[2]), .s_bvalid(bv[2]), .s_bready(bready),
        .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arr[2]),
        .s_rdata(rd[2]), .s_rresp(rr[2]), .s_rvalid(rv[2]), .s_rready(rready),
        .mem_addr(ma[2]), .mem_wdata(mwd[2]), .mem_we(mwe[2]), .mem_rdata(mrd[2]));

    for (genvar g = 0; g < 3; g++) begin : g_mem
        tb_sram_model #(.DEPTH(DEPTH), .AW(4)) u_mem (
            .clk(clk), .addr(ma[g]), .wdata(mwd[g]), .we(mwe[g]), .rdata(mrd[g]));
    end

    int n_chk = 0, n_fail = 0, cyc = 0;
    logic [31:0] m_rw [DEPTH];

    function automatic logic [31:0] seed_word(int i);
        return 32'hA500_0000 + 32'(i) * 32'h0001_0203;
    endfunction

    function automatic logic [31:0] merge(logic [31:0] old, logic [31:0] nw, logic [3:0] s);
        logic [31:0] r = old;
        for (int b = 0; b < 4; b++) if (s[b]) r[8*b +: 8] = nw[8*b +: 8];
        return r;
    endfunction

    function automatic bit in_win(logic [15:0] a);
        return (a >= BASE) && (a < BASE + 16'(4 * DEPTH));
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic finish_bench();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected <100000", cyc);
            finish_bench();
        end
    end

    // Bus write shared by all three copies; the handshake happens at the first edge.
    task automatic do_write(logic [15:0] a, logic [31:0] d, logic [3:0] s);
        bit hit = in_win(a);
        logic [3:0] k = 4'((a - BASE) >> 2);
        awaddr = a; wdata = d; wstrb = s; awvalid = 1; wvalid = 1;
        @(negedge clk);
        awvalid = 0; wvalid = 0;
        for (int i = 0; i < 3; i++) begin
            logic [3:0] ew = (hit && i != 2) ? s : 4'h0;
            chk(mwe[i] == ew, (i == 2) ? "R8 ro write enable" : (hit ? "R3 write enable" : "R9 miss write enable"),
                32'(mwe[i]), 32'(ew));
            chk(bv[i] == 1'b1 && br[i] == 2'b00, "R11 write response OKAY", {bv[i], br[i]}, 32'h4);
            if (hit && i != 2) begin
                chk(ma[i] == k, "R2 element address", 32'(ma[i]), 32'(k));
                chk(mwd[i] == d, "R3 write data", mwd[i], d);
            end
        end
        if (hit) m_rw[k] = merge(m_rw[k], d, s);
        @(negedge clk);
        for (int i = 0; i < 3; i++) chk(mwe[i] == 4'h0, "R3 enable one cycle", 32'(mwe[i]), 0);
        repeat (2) @(negedge clk);
    endtask

    // Bus read shared by all three copies; each copy's data and latency are checked.
    task automatic do_read(logic [15:0] a);
        bit hit = in_win(a);
        logic [3:0] k = 4'((a - BASE) >> 2);
        logic [31:0] exp_d [3];
        int exp_l [3];
        bit got [3];
        exp_d[0] = hit ? m_rw[k] : 32'h0;        exp_l[0] = hit ? 3 : 1;
        exp_d[1] = 32'h0;                         exp_l[1] = 1;
        exp_d[2] = hit ? seed_word(int'(k)) : 0;  exp_l[2] = hit ? 3 : 1;
        got = '{0, 0, 0};
        araddr = a; arvalid = 1;
        for (int t = 1; t <= 5; t++) begin
            @(negedge clk);
            if (t == 1) arvalid = 0;
            if (hit && t < 3) begin
                chk(!arr[0] && !awr[0] && !wrd[0], "R6 busy during read", {arr[0], awr[0], wrd[0]}, 0);
            end
            for (int i = 0; i < 3; i++) begin
                if (rv[i] && !got[i]) begin
                    got[i] = 1;
                    chk(t == exp_l[i], (i == 1) ? "R7 wo read latency" : (hit ? "R5 read latency" : "R9 miss read latency"),
                        32'(t), 32'(exp_l[i]));
                    chk(rd[i] == exp_d[i], (i == 1) ? "R7 wo read zero" : (i == 2 ? "R8 ro data unchanged" :
                        (hit ? "R4 R5 read data" : "R9 miss read zero")), rd[i], exp_d[i]);
                    chk(rr[i] == 2'b00, "R11 read response OKAY", 32'(rr[i]), 0);
                end
            end
        end
        for (int i = 0; i < 3; i++) chk(got[i], "R5 read response seen", 32'(got[i]), 1);
    endtask

    initial begin
        void'($urandom(32'd1357));
        for (int i = 0; i < DEPTH; i++) m_rw[i] = seed_word(i);
        repeat (3) @(negedge clk);
        for (int i = 0; i < 3; i++)
            chk(!bv[i] && !rv[i] && mwe[i] == 4'h0, "R1 reset state", {bv[i], rv[i], mwe[i]}, 0);
        rst_n = 1;
        @(negedge clk);

        // Directed corners: first, last, just outside both edges, offset bits
        do_read(BASE);
        do_read(BASE + 16'd60);
        do_write(BASE, 32'h1122_3344, 4'hF);
        do_read(BASE + 16'd3);
        do_write(BASE + 16'd61, 32'hDEAD_BEEF, 4'h5);
        do_read(BASE + 16'd60);
        do_write(BASE - 16'd4, 32'hFFFF_FFFF, 4'hF);
        do_write(BASE + 16'd64, 32'hFFFF_FFFF, 4'hF);
        do_read(BASE - 16'd1);
        do_read(BASE + 16'd64);
        do_read(BASE + 16'd63);

        // R10: write and read valid together, write goes first
        awaddr = BASE + 16'd8; wdata = 32'h0BAD_F00D; wstrb = 4'hF; awvalid = 1; wvalid = 1;
        araddr = BASE + 16'd8; arvalid = 1;
        #1;
        chk(awr[0] && wrd[0] && !arr[0], "R10 write before read", {awr[0], wrd[0], arr[0]}, 3'b110);
        @(negedge clk);
        awvalid = 0; wvalid = 0;
        m_rw[2] = 32'h0BAD_F00D;
        begin
            int w = 0;
            while (!arr[0] && w < 10) begin @(negedge clk); w++; end
            @(negedge clk);
            arvalid = 0;
            w = 0;
            while (!rv[0] && w < 10) begin @(negedge clk); w++; end
            chk(rv[0] && rd[0] == 32'h0BAD_F00D, "R10 read after write data", rd[0], 32'h0BAD_F00D);
            repeat (4) @(negedge clk);
        end

        // Constrained random mix across and around the window
        for (int n = 0; n < 400; n++) begin
            logic [15:0] a = BASE - 16'd12 + 16'($urandom_range(0, 4 * DEPTH + 23));
            if ($urandom_range(0, 1) == 1) do_write(a, $urandom(), 4'($urandom_range(0, 15)));
            else                           do_read(a);
        end
        finish_bench();
    end
endmodule